// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces the periodic CAS-before-RAS refreshes of a DRAM bus controller. A free-running prescaler divides the system clock by a rate picked from a 3-bit select code. Code 000 stops counting, and the other seven codes give uneven power-of-two ratios. Each divided tick advances a narrow up-counter. When the counter equals a programmable constant, the counter returns to zero and a compare-match flag is raised. The flag can then raise a refresh request toward the DRAM sequencer, a level interrupt, or both.

Software reaches the block through a small word-addressed register bus with four registers: status/control, counter, constant and refresh control. The request output stays high until the sequencer acknowledges it. Two resets exist. Power-on reset clears everything. Manual reset clears everything except the counter.

Top module: `rfsh_interval_timer`

## Requirements
- R1: After power-on reset all four registers read 0, and `rfsh_req` and `cmp_irq` are low.
- R2: The select code sits in status bits 5:3. For a nonzero code s and a constant C, consecutive compare matches are exactly (C+1)·2^k clock cycles apart. k is 1, 3, 5, 7, 9, 11, 12 for s = 1 to 7. Counting starts as soon as a nonzero code is written.
- R3: With select code 000 the counter holds its value.
- R4: The counter register (address 1) and the constant register (address 2) hold CNT_W bits. Higher bits read 0, and writes to them are dropped.
- R5: On a match the counter clears to 0 and the flag (status bit 7) becomes 1, so the counter never exceeds the constant it last reached.
- R6: When refresh control bit 0 (address 3) is 1, a match raises `rfsh_req`. When it is 0, a match raises no request.
- R7: `rfsh_req` stays high until `rfsh_ack` is sampled high, then drops. Matches that occur while a request is pending are discarded and never re-raise it.
- R8: `cmp_irq` is high exactly when the flag and the interrupt enable (status bit 6) are both 1.
- R9: Status bits 2:0 and 15:8 read 0 regardless of what is written.
- R10: Writing 0 to the flag clears it only if the status register was read with the flag at 1 and no status write has come between. Writing 1, or writing 0 without that read, leaves it set.
- R11: Power-on reset zeroes the counter. Manual reset zeroes every other register and the pending request, and leaves the counter value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| mrst_n | input | 1 | Synchronous manual reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for `bus_addr` (combinational) |
| rfsh_req | output | 1 | Refresh request to the DRAM sequencer |
| rfsh_ack | input | 1 | Refresh acknowledge |
| cmp_irq | output | 1 | Compare-match interrupt, level |

## Verification
The bench builds the timer with CNT_W = 4, REG_W = 16 and PS_W = 12. The narrow counter makes the full constant range, including the widest value 15 and the masked upper bits, cheap to cover. The full 12-bit prescaler keeps every select code in play, up to the /4096 rate. Match spacing is measured between successive request rises for all seven codes and several constants, and is compared with (C+1)·2^k computed in the bench. The remaining checks cover the flag read-then-clear rule, request holding with discard of matches during a pending request, and the two reset kinds.

// File: rtl/rit_pkg.sv
package rit_pkg;
   localparam int SEL_W     = 3;
   localparam int NUM_SEL   = 1 << SEL_W;
   localparam int MAX_SHIFT = 12;
   localparam int ADR_W     = 2;

   localparam logic [ADR_W-1:0] ADR_STAT  = 2'd0;
   localparam logic [ADR_W-1:0] ADR_CNT   = 2'd1;
   localparam logic [ADR_W-1:0] ADR_CONST = 2'd2;
   localparam logic [ADR_W-1:0] ADR_RCTL  = 2'd3;

   localparam int BIT_FLAG = 7;
   localparam int BIT_IE   = 6;
   localparam int BIT_SELL = 3;

   // divide exponent for a select code: 0 stops, top code is 2^12, others 2^(2s-1)
   function automatic int rit_shift(input int code);
      if (code == 0)
         return 0;
      else if (code == NUM_SEL - 1)
         return MAX_SHIFT;
      else
         return 2 * code - 1;
   endfunction
endpackage

// File: rtl/rit_prescaler.sv
module rit_prescaler
   import rit_pkg::*;
#(
   parameter int PS_W = 12
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [PS_W-1:0]    ps;
   logic [NUM_SEL-1:0] taps;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         ps <= '0;
      else if (!mrst_n)
         ps <= '0;
      else
         ps <= ps + 1'b1;
   end

   assign taps[0] = 1'b0;
   for (genvar c = 1; c < NUM_SEL; c++) begin : g_tap
      localparam int SH = rit_shift(c);
      assign taps[c] = &ps[SH-1:0];
   end

   assign tick = taps[sel];
endmodule

// File: rtl/rit_count_cmp.sv
module rit_count_cmp #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             match
);
   assign match = tick && run && !load && (cnt == cnst);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (match)
         cnt <= '0;
      else if (tick && run)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rit_regs.sv
module rit_regs
   import rit_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             wr,
   input  logic             rd,
   input  logic [ADR_W-1:0] addr,
   input  logic [REG_W-1:0] wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             match,
   output logic [REG_W-1:0] rdata,
   output logic [SEL_W-1:0] sel,
   output logic             ie,
   output logic             flag,
   output logic             rfsh_en,
   output logic [CNT_W-1:0] cnst,
   output logic             cnt_wr,
   output logic             stat_wr
);
   logic armed;
   logic stat_rd;

   assign stat_wr = wr && (addr == ADR_STAT);
   assign cnt_wr  = wr && (addr == ADR_CNT);
   assign stat_rd = rd && (addr == ADR_STAT);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sel     <= '0;
         ie      <= 1'b0;
         flag    <= 1'b0;
         armed   <= 1'b0;
         rfsh_en <= 1'b0;
         cnst    <= '0;
      end else if (!mrst_n) begin
         sel     <= '0;
         ie      <= 1'b0;
         flag    <= 1'b0;
         armed   <= 1'b0;
         rfsh_en <= 1'b0;
         cnst    <= '0;
      end else begin
         if (stat_wr) begin
            sel <= wdata[BIT_SELL +: SEL_W];
            ie  <= wdata[BIT_IE];
         end
         if (wr && addr == ADR_CONST)
            cnst <= wdata[CNT_W-1:0];
         if (wr && addr == ADR_RCTL)
            rfsh_en <= wdata[0];

         if (match)
            flag <= 1'b1;
         else if (stat_wr && armed && !wdata[BIT_FLAG])
            flag <= 1'b0;

         if (stat_wr)
            armed <= 1'b0;
         else if (stat_rd && flag)
            armed <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADR_STAT: begin
            rdata[BIT_FLAG]           = flag;
            rdata[BIT_IE]             = ie;
            rdata[BIT_SELL +: SEL_W]  = sel;
         end
         ADR_CNT:   rdata[CNT_W-1:0] = cnt;
         ADR_CONST: rdata[CNT_W-1:0] = cnst;
         default:   rdata[0]         = rfsh_en;
      endcase
   end
endmodule

// File: rtl/rit_refresh_req.sv
module rit_refresh_req (
   input  logic clk,
   input  logic por_n,
   input  logic mrst_n,
   input  logic match,
   input  logic enable,
   input  logic ack,
   output logic req
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         req <= 1'b0;
      else if (!mrst_n)
         req <= 1'b0;
      else if (req)
         req <= !ack;
      else
         req <= match && enable;
   end
endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer
   import rit_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int REG_W = 16,
   parameter int PS_W  = 12
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             mrst_n,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   output logic             rfsh_req,
   input  logic             rfsh_ack,
   output logic             cmp_irq
);
   if (REG_W < 8)
      $error("REG_W must hold the 8-bit status field");
   if (CNT_W < 1 || CNT_W > REG_W)
      $error("CNT_W must be between 1 and REG_W");
   if (PS_W < MAX_SHIFT)
      $error("PS_W must cover the widest divide ratio");

   logic             tick;
   logic             run;
   logic             match;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnst;
   logic [SEL_W-1:0] sel;
   logic             ie;
   logic             flag;
   logic             rfsh_en;
   logic             cnt_wr;
   logic             stat_wr;

   assign run     = mrst_n && (sel != '0);
   assign cmp_irq = flag && ie;

   rit_prescaler #(.PS_W(PS_W)) u_pre (
      .clk    (clk),
      .por_n  (por_n),
      .mrst_n (mrst_n),
      .sel    (sel),
      .tick   (tick)
   );

   rit_count_cmp #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .por_n    (por_n),
      .run      (run),
      .tick     (tick),
      .cnst     (cnst),
      .load     (cnt_wr),
      .load_val (bus_wdata[CNT_W-1:0]),
      .cnt      (cnt),
      .match    (match)
   );

   rit_regs #(.CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
      .clk     (clk),
      .por_n   (por_n),
      .mrst_n  (mrst_n),
      .wr      (bus_wr),
      .rd      (bus_rd),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .cnt     (cnt),
      .match   (match),
      .rdata   (bus_rdata),
      .sel     (sel),
      .ie      (ie),
      .flag    (flag),
      .rfsh_en (rfsh_en),
      .cnst    (cnst),
      .cnt_wr  (cnt_wr),
      .stat_wr (stat_wr)
   );

   rit_refresh_req u_req (
      .clk    (clk),
      .por_n  (por_n),
      .mrst_n (mrst_n),
      .match  (match),
      .enable (rfsh_en),
      .ack    (rfsh_ack),
      .req    (rfsh_req)
   );
endmodule

// File: rtl/rit_chk.sv
module rit_chk #(
   parameter int CNT_W = 8,
   parameter int REG_W = 16
) (
   input logic             clk,
   input logic             por_n,
   input logic             mrst_n,
   input logic [2:0]       sel,
   input logic [CNT_W-1:0] cnt,
   input logic             match,
   input logic             flag,
   input logic             stat_wr,
   input logic             cnt_wr,
   input logic             rfsh_req,
   input logic             rfsh_ack,
   input logic [1:0]       bus_addr,
   input logic [REG_W-1:0] bus_rdata
);
   // R5
   count_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
      match |=> (cnt == '0));

   // R5
   flag_set_chk: assert property (@(posedge clk) disable iff (!por_n)
      match |=> flag);

   // R3
   stop_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

   // R7
   req_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (rfsh_req && !rfsh_ack && mrst_n) |=> rfsh_req);

   // R7
   req_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rfsh_req) |-> ($past(rfsh_ack) || !$past(mrst_n)));

   // R4
   upper_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
      (bus_addr == 2'd1) |-> ((bus_rdata >> CNT_W) == '0));

   // R10
   flag_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      (flag && !stat_wr && mrst_n) |=> flag);

   // R11
   mrst_cnt_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!mrst_n && !cnt_wr) |=> $stable(cnt));
endmodule

bind rfsh_interval_timer rit_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .mrst_n    (mrst_n),
   .sel       (sel),
   .cnt       (cnt),
   .match     (match),
   .flag      (flag),
   .stat_wr   (stat_wr),
   .cnt_wr    (cnt_wr),
   .rfsh_req  (rfsh_req),
   .rfsh_ack  (rfsh_ack),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata)
);

// File: tb/tb_rfsh_interval_timer.sv
module tb_rfsh_interval_timer;
   localparam int CNT_W = 4;
   localparam int REG_W = 16;

   logic             clk = 1'b0;
   logic             por_n = 1'b0;
   logic             mrst_n = 1'b1;
   logic             bus_wr = 1'b0;
   logic             bus_rd = 1'b0;
   logic [1:0]       bus_addr = '0;
   logic [REG_W-1:0] bus_wdata = '0;
   logic [REG_W-1:0] bus_rdata;
   logic             rfsh_req;
   logic             rfsh_ack = 1'b0;
   logic             cmp_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rfsh_interval_timer #(.CNT_W(CNT_W), .REG_W(REG_W), .PS_W(12)) dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rfsh_req(rfsh_req), .rfsh_ack(rfsh_ack), .cmp_irq(cmp_irq)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // measure spacing of request rises for code s and constant c (R2, R6)
   task automatic interval(input int s, input int c);
      int k;
      int per;
      int cyc;
      int n;
      int rises[3];
      k   = (s == 7) ? 12 : 2 * s - 1;
      per = (c + 1) << k;
      wr(2'd3, 16'h0001);
      wr(2'd2, REG_W'(c));
      wr(2'd0, REG_W'(s << 3));
      cyc = 0; n = 0;
      while (n < 3 && cyc < 4 * per + 100) begin
         @(negedge clk);
         cyc++;
         rfsh_ack = 1'b0;
         if (rfsh_req) begin
            rises[n] = cyc;
            n++;
            rfsh_ack = 1'b1;
         end
      end
      chk($sformatf("R6 request count s=%0d c=%0d", s, c), n, 3);
      if (n == 3) begin
         chk($sformatf("R2 period s=%0d c=%0d", s, c), rises[1] - rises[0], per);
         chk($sformatf("R2 period2 s=%0d c=%0d", s, c), rises[2] - rises[1], per);
      end
      wr(2'd0, 16'h0000);
      @(negedge clk); rfsh_ack = 1'b1;
      @(negedge clk); rfsh_ack = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [REG_W-1:0] v;
      logic [REG_W-1:0] c0;
      bit bad;
      repeat (3) @(negedge clk);
      por_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk($sformatf("R1 reg%0d", a), v, 0);
      end
      chk("R1 rfsh_req", rfsh_req, 0);
      chk("R1 cmp_irq", cmp_irq, 0);

      // R9 reserved status bits; ie set, select 000
      wr(2'd0, 16'hFF47);
      rd(2'd0, v);
      chk("R9 status readback", v, 16'h0040);
      chk("R8 irq with flag clear", cmp_irq, 0);

      // R4 counter/constant width
      wr(2'd1, 16'hFFFF);
      rd(2'd1, v);
      chk("R4 counter upper bits", v, 16'h000F);
      wr(2'd2, 16'hFFF7);
      rd(2'd2, v);
      chk("R4 constant upper bits", v, 16'h0007);

      // R3 stopped counter holds
      repeat (100) @(negedge clk);
      rd(2'd1, v);
      chk("R3 counter held", v, 16'h000F);

      // R5 / R8 / R10 / R6 negative
      wr(2'd2, 16'h0005);
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'h0008);
      repeat (40) @(negedge clk);
      rd(2'd0, v);
      chk("R5 flag set", v, 16'h0088);
      chk("R8 irq masked", cmp_irq, 0);
      chk("R6 no request when disabled", rfsh_req, 0);
      wr(2'd0, 16'h00C0);
      rd(2'd1, v);
      chk("R5 counter within constant", (v <= 16'd5), 1);
      chk("R8 irq raised", cmp_irq, 1);
      wr(2'd0, 16'h0040);
      rd(2'd0, v);
      chk("R10 clear without read ignored", v, 16'h00C0);
      wr(2'd0, 16'h0040);
      rd(2'd0, v);
      chk("R10 clear after read", v, 16'h0040);
      chk("R8 irq dropped", cmp_irq, 0);
      wr(2'd0, 16'h0000);

      // R2 sweep over codes and constants
      interval(1, 0);
      interval(1, 1);
      interval(1, 3);
      interval(1, 15);
      for (int s = 2; s < 8; s++) interval(s, 1);
      interval(3, 6);

      // R7 request hold and discard
      wr(2'd2, 16'h0001);
      wr(2'd3, 16'h0001);
      wr(2'd0, 16'h0008);
      for (int i = 0; i < 30 && !rfsh_req; i++) @(negedge clk);
      chk("R7 request seen", rfsh_req, 1);
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!rfsh_req) bad = 1;
      end
      chk("R7 request held without ack", bad, 0);
      wr(2'd0, 16'h0000);
      @(negedge clk); rfsh_ack = 1'b1;
      @(negedge clk); rfsh_ack = 1'b0;
      chk("R7 request dropped on ack", rfsh_req, 0);
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (rfsh_req) bad = 1;
      end
      chk("R7 no queued request", bad, 0);

      // R11 manual reset then power-on reset
      wr(2'd2, 16'h000C);
      wr(2'd1, 16'h0009);
      wr(2'd0, 16'h0048);
      repeat (30) @(negedge clk);
      wr(2'd0, 16'h0040);
      chk("R11 pre-reset request pending", rfsh_req, 1);
      rd(2'd1, c0);
      @(negedge clk); mrst_n = 1'b0;
      repeat (2) @(negedge clk);
      mrst_n = 1'b1;
      rd(2'd1, v);
      chk("R11 counter kept by manual reset", v, c0);
      rd(2'd0, v);
      chk("R11 status cleared", v, 0);
      rd(2'd2, v);
      chk("R11 constant cleared", v, 0);
      rd(2'd3, v);
      chk("R11 refresh enable cleared", v, 0);
      chk("R11 request cleared", rfsh_req, 0);
      chk("R11 irq cleared", cmp_irq, 0);
      wr(2'd1, 16'h0006);
      @(negedge clk); por_n = 1'b0;
      repeat (2) @(negedge clk);
      por_n = 1'b1;
      rd(2'd1, v);
      chk("R11 counter zeroed by power-on", v, 0);

      summary();
   end
endmodule